// File: doc/BRIEF.md
# Receive Frame Buffer Writer

This block stores one incoming Ethernet frame into a page of packet memory, using the layout the receive path of the controller expects. The frame arrives as a byte stream. Its total length is presented with the first byte. The writer first checks whether the frame may be kept at all. It then asks the page allocator for a page and holds the stream back until the allocator answers.

Once a page is granted, the writer fills it one byte per cycle in a fixed order:
- a four-byte header with flags and the stored size;
- the frame data, with short frames zero-filled;
- an optional four-byte CRC;
- a two-byte trailer that carries a held odd byte and a marker.

After the last byte it pulses a completion strobe with the page number. The surrounding logic uses that strobe to queue the page for software and to raise the receive interrupt. A frame that cannot be stored produces a single drop strobe instead, and the writer still consumes all of its bytes.

Top module: `rx_frame_writer`

## Requirements
- R1: When the first byte of a frame is presented while `rx_enable` is low or `rx_soft_rst` is high, `frame_drop` pulses once. No page is requested, nothing is written, and every byte of the frame is still consumed.
- R2: Bytes 2 (low) and 3 (high) of the page hold the stored size. The base is 64 when the length is below 64, otherwise the length with bit 0 cleared. The stored size is this base plus 6, plus another 4 when `rx_strip_crc` is low.
- R3: Bytes 0 (low) and 1 (high) hold a flag word. Bit 11 is set when the length exceeds 1518. Bit 12 is set when the length is odd. All other bits are zero.
- R4: Frame byte i is stored at page address 4+i. The exception is a frame of 64 bytes or more with odd length: its last byte is not stored there.
- R5: A frame shorter than 64 bytes has all of its bytes stored from address 4, including an odd last byte. Zeros follow up to address 67, and the frame is then handled as an even 64-byte frame, so its trailer is 0x00 then 0x40.
- R6: When `rx_strip_crc` is low, four CRC bytes follow the data region, least significant byte first. The CRC is the reflected Ethernet CRC-32 (polynomial 0xEDB88320, preset all ones, result inverted). It is taken over every data byte, padding and an odd last byte included. When `rx_strip_crc` is high, no CRC bytes are written.
- R7: The last two bytes written are the held odd byte followed by 0x60 for odd frames of 64 bytes or more. For all other frames they are 0x00 followed by 0x40.
- R8: A frame whose stored size would exceed the page size (2048) is dropped without a page request or any write. A stored size of exactly 2048 is accepted.
- R9: When the allocator answers with `alloc_ok` low, the frame is dropped and nothing is written.
- R10: `in_ready` stays low while a page request is pending. Every write goes to the granted page, below the stored size, and the number of writes equals the stored size.
- R11: Each frame ends in exactly one `frame_done` or one `frame_drop`. `frame_done` comes with the last write and carries the granted page on `done_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_enable | input | 1 | Receive enable control bit |
| rx_soft_rst | input | 1 | Soft reset control bit; frames are refused while high |
| rx_strip_crc | input | 1 | When high, no CRC is stored |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Stream byte accepted when high together with `in_valid` |
| in_data | input | 8 | Stream byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_len | input | LEN_W (16) | Frame length in bytes, valid with the first byte |
| alloc_req | output | 1 | Page request, held until answered |
| alloc_resp | input | 1 | Allocator answer strobe |
| alloc_ok | input | 1 | Answer carries a page |
| alloc_page | input | PG_W (2) | Granted page number |
| ram_we | output | 1 | Packet memory byte write enable |
| ram_page | output | PG_W (2) | Page of the write |
| ram_addr | output | ADDR_W (11) | Byte address within the page |
| ram_wdata | output | 8 | Byte written |
| frame_done | output | 1 | Frame stored; page ready for the receive queue |
| done_page | output | PG_W (2) | Page of the stored frame |
| frame_drop | output | 1 | Frame refused |

## Verification
The bench uses the default parameters: 2048-byte pages, four pages, a 64-byte minimum and 1518 as the long-frame limit. These values keep every boundary of the size rule within reach. Two frames land exactly on a 2048-byte stored size, one with CRC and one without. Two frames overshoot it by only a few bytes. Frames of length 63 and 64 straddle the padding edge, and a 1600-byte frame sets the long flag. Four distinct pages and grant delays from zero to several cycles show that writes follow the grant and that the stream stays stalled while the request is open.

// File: rtl/rxw_pkg.sv
// Shared types and the CRC step used by the receive frame buffer writer.
// Assumes byte-serial CRC accumulation, least significant bit first.
package rxw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DRAIN,
        S_ALLOC,
        S_HDR,
        S_DATA,
        S_PAD,
        S_CRC,
        S_TAIL0,
        S_TAIL1
    } rxw_state_t;

    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    // Advance a reflected CRC-32 register by one byte.
    function automatic logic [31:0] crc32_step(input logic [31:0] cur, input logic [7:0] din);
        logic [31:0] r;
        r = cur;
        for (int b = 0; b < 8; b++) begin
            if (r[0] ^ din[b]) r = (r >> 1) ^ CRC_POLY;
            else               r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/rxw_sizer.sv
// Stored-size and flag-word calculation for one frame.
// Assumes LEN_W is at least 15 so the size fits its two header bytes.
module rxw_sizer #(
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 2048,
    parameter int MIN_DATA   = 64,
    parameter int MAX_STD    = 1518
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip_crc,
    output logic [LEN_W:0]   stored_size,
    output logic [15:0]      status_word,
    output logic             too_big,
    output logic             is_short,
    output logic             is_odd
);
    localparam int OVERHEAD = 6;
    localparam int CRC_LEN  = 4;

    logic [LEN_W:0] base;

    // Base data length, padded size and the page-fit test.
    always_comb begin
        is_short = len < LEN_W'(MIN_DATA);
        is_odd   = len[0];
        base     = is_short ? (LEN_W+1)'(MIN_DATA) : {1'b0, len[LEN_W-1:1], 1'b0};
        stored_size = base + (LEN_W+1)'(OVERHEAD)
                    + (strip_crc ? '0 : (LEN_W+1)'(CRC_LEN));
        too_big  = stored_size > (LEN_W+1)'(PAGE_BYTES);
    end

    // Flag word: bit 12 odd length, bit 11 longer than the standard maximum.
    always_comb begin
        status_word     = '0;
        status_word[12] = is_odd;
        status_word[11] = len > LEN_W'(MAX_STD);
    end

endmodule

// File: rtl/rxw_crc.sv
// Byte-serial CRC-32 accumulator; the output is the inverted register.
// Assumes clear and en are not asserted together.
module rxw_crc
    import rxw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_val
);
    logic [31:0] acc_q;

    // Preset on clear, fold in one byte on en.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= CRC_INIT;
        else if (clear) acc_q <= CRC_INIT;
        else if (en)    acc_q <= crc32_step(acc_q, din);
    end

    assign crc_val = ~acc_q;

endmodule

// File: rtl/rx_frame_writer.sv
// Receive frame buffer writer: stores one streamed frame into a granted
// packet page in the order header, data, padding, CRC, trailer.
// Assumes in_len matches the number of bytes up to and including in_eof,
// and in_len is at least 1.
module rx_frame_writer
    import rxw_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int NUM_PAGES  = 4,
    parameter int LEN_W      = 16,
    parameter int MIN_DATA   = 64,
    parameter int MAX_STD    = 1518,
    localparam int ADDR_W    = $clog2(PAGE_BYTES),
    localparam int PG_W      = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              rx_soft_rst,
    input  logic              rx_strip_crc,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [LEN_W-1:0]  in_len,
    output logic              alloc_req,
    input  logic              alloc_resp,
    input  logic              alloc_ok,
    input  logic [PG_W-1:0]   alloc_page,
    output logic              ram_we,
    output logic [PG_W-1:0]   ram_page,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    output logic              frame_done,
    output logic [PG_W-1:0]   done_page,
    output logic              frame_drop
);
    localparam int PAD_LAST = 4 + MIN_DATA - 1;

    rxw_state_t        state_q, state_d;
    logic [LEN_W-1:0]  len_q;
    logic              strip_q;
    logic [PG_W-1:0]   page_q;
    logic [ADDR_W-1:0] wptr_q;
    logic [7:0]        odd_q;
    logic [1:0]        crc_idx_q;

    logic [LEN_W-1:0]  sz_len;
    logic              sz_strip;
    logic [LEN_W:0]    stored_size;
    logic [15:0]       status_word;
    logic              too_big, is_short, is_odd, keep_odd;

    logic              crc_clear, crc_en;
    logic [7:0]        crc_din;
    logic [31:0]       crc_val, crc_sh;

    // Size the incoming frame while idle, the latched frame afterwards.
    assign sz_len   = (state_q == S_IDLE) ? in_len : len_q;
    assign sz_strip = (state_q == S_IDLE) ? rx_strip_crc : strip_q;

    rxw_sizer #(
        .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MIN_DATA(MIN_DATA), .MAX_STD(MAX_STD)
    ) u_sizer (
        .len(sz_len), .strip_crc(sz_strip), .stored_size(stored_size),
        .status_word(status_word), .too_big(too_big), .is_short(is_short), .is_odd(is_odd)
    );

    rxw_crc u_crc (
        .clk(clk), .rst_n(rst_n), .clear(crc_clear), .en(crc_en),
        .din(crc_din), .crc_val(crc_val)
    );

    assign keep_odd  = is_odd && !is_short;
    assign crc_sh    = crc_val >> {crc_idx_q, 3'b000};
    assign ram_addr  = wptr_q;
    assign ram_page  = page_q;
    assign done_page = page_q;

    // Next state, stream handshake, write port and strobes.
    always_comb begin
        state_d    = state_q;
        in_ready   = 1'b0;
        alloc_req  = 1'b0;
        ram_we     = 1'b0;
        ram_wdata  = 8'h00;
        frame_done = 1'b0;
        frame_drop = 1'b0;
        crc_clear  = 1'b0;
        crc_en     = 1'b0;
        crc_din    = in_data;
        case (state_q)
            S_IDLE: begin
                in_ready = in_valid && !in_sof;
                if (in_valid && in_sof) begin
                    if (!rx_enable || rx_soft_rst || too_big) begin
                        frame_drop = 1'b1;
                        state_d    = S_DRAIN;
                    end else begin
                        state_d    = S_ALLOC;
                    end
                end
            end
            S_DRAIN: begin
                in_ready = 1'b1;
                if (in_valid && in_eof) state_d = S_IDLE;
            end
            S_ALLOC: begin
                alloc_req = 1'b1;
                if (alloc_resp) begin
                    if (alloc_ok) begin
                        crc_clear = 1'b1;
                        state_d   = S_HDR;
                    end else begin
                        frame_drop = 1'b1;
                        state_d    = S_DRAIN;
                    end
                end
            end
            S_HDR: begin
                ram_we = 1'b1;
                case (wptr_q[1:0])
                    2'd0:    ram_wdata = status_word[7:0];
                    2'd1:    ram_wdata = status_word[15:8];
                    2'd2:    ram_wdata = stored_size[7:0];
                    default: ram_wdata = stored_size[15:8];
                endcase
                if (wptr_q[1:0] == 2'd3) state_d = S_DATA;
            end
            S_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    crc_en    = 1'b1;
                    ram_we    = !(in_eof && keep_odd);
                    ram_wdata = in_data;
                    if (in_eof)
                        state_d = is_short ? S_PAD : (strip_q ? S_TAIL0 : S_CRC);
                end
            end
            S_PAD: begin
                ram_we  = 1'b1;
                crc_en  = 1'b1;
                crc_din = 8'h00;
                if (wptr_q == ADDR_W'(PAD_LAST)) state_d = strip_q ? S_TAIL0 : S_CRC;
            end
            S_CRC: begin
                ram_we    = 1'b1;
                ram_wdata = crc_sh[7:0];
                if (crc_idx_q == 2'd3) state_d = S_TAIL0;
            end
            S_TAIL0: begin
                ram_we    = 1'b1;
                ram_wdata = keep_odd ? odd_q : 8'h00;
                state_d   = S_TAIL1;
            end
            S_TAIL1: begin
                ram_we     = 1'b1;
                ram_wdata  = keep_odd ? 8'h60 : 8'h40;
                frame_done = 1'b1;
                state_d    = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Latch length and CRC mode when a frame's first byte is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            strip_q <= 1'b0;
        end else if (state_q == S_IDLE && in_valid && in_sof) begin
            len_q   <= in_len;
            strip_q <= rx_strip_crc;
        end
    end

    // Capture the granted page and advance the write pointer per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            wptr_q <= '0;
        end else if (state_q == S_ALLOC && alloc_resp && alloc_ok) begin
            page_q <= alloc_page;
            wptr_q <= '0;
        end else if (ram_we) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    // Hold the final stream byte for the trailer and count CRC bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q     <= 8'h00;
            crc_idx_q <= 2'd0;
        end else begin
            if (state_q == S_DATA && in_valid && in_eof) odd_q <= in_data;
            crc_idx_q <= (state_q == S_CRC) ? crc_idx_q + 2'd1 : 2'd0;
        end
    end

    // R10: the stream is held while the page request is open.
    a_r10_stall_during_alloc: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> !in_ready);

    // R10: writes stay below the stored size of the frame.
    a_r10_write_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ((LEN_W+1)'(ram_addr) < stored_size));

    // R11: a frame never both completes and drops.
    a_r11_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_drop));

    // R11: completion marks the final write of the frame.
    a_r11_done_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !ram_we);

    // R1: a refused frame causes no request and no write afterwards.
    a_r1_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |=> (!ram_we && !alloc_req));

    // R7: the closing byte is one of the two trailer markers.
    a_r7_tail_marker: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (ram_wdata == 8'h40 || ram_wdata == 8'h60));

endmodule

// File: tb/tb_rx_frame_writer.sv
module tb_rx_frame_writer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_enable, rx_soft_rst, rx_strip_crc;
    logic        in_valid, in_ready, in_sof, in_eof;
    logic [7:0]  in_data;
    logic [15:0] in_len;
    logic        alloc_req, alloc_resp, alloc_ok;
    logic [1:0]  alloc_page;
    logic        ram_we;
    logic [1:0]  ram_page;
    logic [10:0] ram_addr;
    logic [7:0]  ram_wdata;
    logic        frame_done, frame_drop;
    logic [1:0]  done_page;

    int checks = 0;
    int fails  = 0;
    int gnt_delay = 0;
    int wait_ctr  = 0;
    int wcount, bad_page, stall_viol, req_seen, done_cnt, drop_cnt;
    logic [1:0] exp_page;
    logic [1:0] got_page;
    logic [7:0] mem [0:2047];
    logic [7:0] expm [0:2047];
    int exp_size;

    always #5 clk = ~clk;

    rx_frame_writer dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_soft_rst(rx_soft_rst),
        .rx_strip_crc(rx_strip_crc), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof), .in_len(in_len),
        .alloc_req(alloc_req), .alloc_resp(alloc_resp), .alloc_ok(alloc_ok),
        .alloc_page(alloc_page), .ram_we(ram_we), .ram_page(ram_page),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .frame_done(frame_done),
        .done_page(done_page), .frame_drop(frame_drop)
    );

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 7 + seed * 13 + 1) & 255);
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic clear_counts();
        wcount = 0; bad_page = 0; stall_viol = 0; req_seen = 0; done_cnt = 0; drop_cnt = 0;
        for (int a = 0; a < 2048; a++) mem[a] = 8'hA5;
    endtask

    // Monitor: sampled at the falling edge, away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (ram_we) begin
                    mem[ram_addr] = ram_wdata;
                    wcount++;
                    if (ram_page !== exp_page) bad_page++;
                end
                if (alloc_req) req_seen++;
                if (alloc_req && in_ready) stall_viol++;
                if (frame_done) begin done_cnt++; got_page = done_page; end
                if (frame_drop) drop_cnt++;
            end
        end
    end

    // Allocator model: answers a held request after gnt_delay cycles.
    initial begin
        alloc_resp = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (alloc_resp) alloc_resp = 1'b0;
            else if (alloc_req) begin
                if (wait_ctr >= gnt_delay) begin alloc_resp = 1'b1; wait_ctr = 0; end
                else wait_ctr++;
            end else wait_ctr = 0;
        end
    end

    task automatic send_frame(input int len, input int seed);
        @(posedge clk); #1;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == len - 1);
            in_data  = pat(i, seed);
            in_len   = 16'(len);
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            @(posedge clk); #1;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic build_expected(input int len, input bit strip, input int seed);
        int base, d, p;
        logic [15:0] st;
        logic [31:0] c;
        logic [7:0]  b;
        base = (len < 64) ? 64 : (len & ~1);
        exp_size = base + 6 + (strip ? 0 : 4);
        st = 16'h0;
        if (len > 1518) st[11] = 1'b1;
        if (len % 2)    st[12] = 1'b1;
        expm[0] = st[7:0]; expm[1] = st[15:8];
        expm[2] = 8'(exp_size & 255); expm[3] = 8'(exp_size >> 8);
        for (int i = 0; i < base; i++) expm[4 + i] = (i < len) ? pat(i, seed) : 8'h00;
        d = (len < 64) ? 64 : len;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < d; i++) begin
            b = (i < len) ? pat(i, seed) : 8'h00;
            c = c ^ {24'h0, b};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        p = 4 + base;
        if (!strip) begin
            for (int k = 0; k < 4; k++) expm[p + k] = 8'(c >> (8 * k));
            p = p + 4;
        end
        if (len >= 64 && (len % 2) == 1) begin
            expm[p] = pat(len - 1, seed); expm[p + 1] = 8'h60;
        end else begin
            expm[p] = 8'h00; expm[p + 1] = 8'h40;
        end
    endtask

    // Stores one frame and compares the page image region by region.
    task automatic run_ok(input int len, input bit strip, input int page,
                          input int delay, input int seed);
        int base, p, bad;
        string dtag, ttag;
        build_expected(len, strip, seed);
        rx_enable = 1'b1; rx_soft_rst = 1'b0; rx_strip_crc = strip;
        alloc_ok = 1'b1; alloc_page = 2'(page); exp_page = 2'(page); gnt_delay = delay;
        clear_counts();
        send_frame(len, seed);
        repeat (100) @(posedge clk);
        #1;
        base = (len < 64) ? 64 : (len & ~1);
        dtag = (len < 64) ? "R5 padded data" : "R4 data placement";
        ttag = (len < 64) ? "R5 short trailer" : "R7 trailer";
        chk(done_cnt == 1 && drop_cnt == 0, "R11 one completion", done_cnt, 1);
        chk(got_page == 2'(page), "R11 done page", int'(got_page), page);
        chk(wcount == exp_size, "R10 write count", wcount, exp_size);
        chk(bad_page == 0 && stall_viol == 0, "R10 page and stall", bad_page + stall_viol, 0);
        chk(mem[0] == expm[0] && mem[1] == expm[1], "R3 flag word",
            int'({mem[1], mem[0]}), int'({expm[1], expm[0]}));
        chk(mem[2] == expm[2] && mem[3] == expm[3], "R2 stored size",
            int'({mem[3], mem[2]}), int'({expm[3], expm[2]}));
        bad = 0;
        for (int i = 4; i < 4 + base; i++) if (mem[i] !== expm[i]) bad++;
        chk(bad == 0, dtag, bad, 0);
        p = 4 + base;
        if (!strip) begin
            chk({mem[p+3], mem[p+2], mem[p+1], mem[p]} === {expm[p+3], expm[p+2], expm[p+1], expm[p]},
                "R6 crc bytes", int'({mem[p+3], mem[p+2], mem[p+1], mem[p]}),
                int'({expm[p+3], expm[p+2], expm[p+1], expm[p]}));
            p = p + 4;
        end
        chk(mem[p] === expm[p] && mem[p+1] === expm[p+1], ttag,
            int'({mem[p], mem[p+1]}), int'({expm[p], expm[p+1]}));
        chk(mem[exp_size] === 8'hA5 || exp_size == 2048, "R10 nothing past size",
            int'(mem[exp_size % 2048]), 165);
    endtask

    // Expects a refused frame: one drop strobe, no writes, optional request.
    task automatic run_drop(input int len, input bit en, input bit srst, input bit strip,
                            input bit ok, input string tag);
        rx_enable = en; rx_soft_rst = srst; rx_strip_crc = strip;
        alloc_ok = ok; alloc_page = 2'd1; exp_page = 2'd1; gnt_delay = 1;
        clear_counts();
        send_frame(len, 5);
        repeat (20) @(posedge clk);
        #1;
        chk(drop_cnt == 1 && done_cnt == 0, tag, drop_cnt, 1);
        chk(wcount == 0, tag, wcount, 0);
        if (ok) chk(req_seen == 0, tag, req_seen, 0);
        else    chk(req_seen > 0, tag, req_seen, 1);
    endtask

    task automatic t_reset();
        #1;
        chk(in_ready == 1'b0 && alloc_req == 1'b0, "R10 reset quiet", int'({in_ready, alloc_req}), 0);
        chk(ram_we == 1'b0, "R10 reset no write", int'(ram_we), 0);
        chk(frame_done == 1'b0 && frame_drop == 1'b0, "R11 reset strobes",
            int'({frame_done, frame_drop}), 0);
    endtask

    task automatic t_long_frames();
        run_ok(100, 1'b0, 2, 3, 1);    // R4 R6 R7 even, stalled grant
        run_ok(101, 1'b0, 1, 0, 2);    // R7 odd byte held, 0x60 marker
        run_ok(64, 1'b0, 3, 1, 3);     // R5 boundary: no padding at 64
        run_ok(1600, 1'b1, 0, 2, 4);   // R3 long flag, CRC stripped
    endtask

    task automatic t_short_frames();
        run_ok(37, 1'b1, 3, 0, 6);     // R5 odd short, stripped
        run_ok(20, 1'b0, 0, 4, 7);     // R5 even short, CRC over padding
        run_ok(63, 1'b0, 2, 0, 8);     // R5 one pad byte
    endtask

    task automatic t_size_edges();
        run_ok(2039, 1'b0, 1, 0, 9);   // R8 exact 2048 with CRC
        run_ok(2043, 1'b1, 2, 0, 10);  // R8 exact 2048 stripped
        run_drop(2041, 1'b1, 1'b0, 1'b0, 1'b1, "R8 oversize with crc");
        run_drop(2047, 1'b1, 1'b0, 1'b1, 1'b1, "R8 oversize stripped");
    endtask

    task automatic t_refused();
        run_drop(80, 1'b0, 1'b0, 1'b0, 1'b1, "R1 receive disabled");
        run_drop(1, 1'b1, 1'b1, 1'b1, 1'b1, "R1 soft reset");
        run_drop(70, 1'b1, 1'b0, 1'b0, 1'b0, "R9 no page");
        run_ok(66, 1'b0, 1, 0, 11);    // recovery after drops
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rx_enable = 1'b0; rx_soft_rst = 1'b0; rx_strip_crc = 1'b0;
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00; in_len = 16'h0;
        alloc_ok = 1'b0; alloc_page = 2'd0; exp_page = 2'd0; got_page = 2'd0;
        clear_counts();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_long_frames();
        t_short_frames();
        t_size_edges();
        t_refused();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule